// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block holds the programmable state of an interrupt router with a parameterised number of input pins. Software reaches it through only two 32-bit bus locations: a select register that names an internal register, and a data window that reads or writes the register currently selected. Behind the window sit a 4-bit identification register, a read-only version word, and one 64-bit routing entry per pin. Each entry is accessed as two 32-bit halves.

Every entry's fields are exported as flat vectors to the delivery logic. These fields are vector, delivery mode, destination mode, polarity, trigger mode, mask, destination, delivery status and remote IRR. The delivery logic in turn sets and clears the two status bits through per-pin strobe inputs. Software can never alter those two bits: a write to the low half of an entry keeps the stored remote IRR and clears delivery status. After every such write, a one-cycle pulse carries the entry index, so that trigger logic can re-examine level-sensitive pins.

The bus side is a simple single-cycle strobe interface with no back-pressure. A read strobe always produces its data one cycle later, flagged by `bus_rvalid`. A write strobe always completes at the sampling edge. The status and export pins are plain level signals.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, the select register and the ID are zero, and every entry holds 0x0000_0000_0001_0000, with the mask (bit 16) set. A low-half read of any entry therefore returns 0x0001_0000 and a high-half read returns 0.
- R2: Bus offset 0x00 is the select register and bus offset 0x10 is the data window. Reads at any other offset return 0, and writes there change nothing.
- R3: Writing the select offset stores write data bits 7:0. Reading that offset returns them zero-extended.
- R4: With select 0x01, the window reads {8'h00, NUM_PINS-1, 8'h00, VERSION_ID}. Writes to it have no effect.
- R5: With select 0x00, a window write stores data bits 27:24 as the ID. A read returns the ID in bits 27:24, with all other bits 0.
- R6: Select 0x10+2n reaches bits 31:0 of entry n and select 0x11+2n reaches bits 63:32.
- R7: A select of 0x02..0x0F, or one whose entry index is NUM_PINS or more, reads as 0. A window write to such a select changes nothing and raises no pulse.
- R8: A high-half write replaces bits 63:32 only. The exported destination is bits 63:56.
- R9: A low-half write replaces bits 31:0, but stores delivery status (bit 12) as 0 and keeps the previous remote IRR (bit 14), even when the hardware sets delivery status in the same cycle.
- R10: `lo_wr_pulse` is high for exactly the cycle after each in-range low-half write, with `lo_wr_idx` equal to the entry index. No other write raises it.
- R11: `hw_irr_clr` clears remote IRR and beats `hw_irr_set` in the same cycle. `hw_dstat_set` sets delivery status and beats `hw_dstat_clr`. Each takes effect at the next clock edge.
- R12: Read data and `bus_rvalid` appear one cycle after the read strobe and reflect state before any write in that same cycle. When `bus_rvalid` is low, `bus_rdata` is 0.
- R13: The low word exports vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote IRR [14], trigger mode [15] and mask [16], per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Bus byte offset (low address bits) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| hw_irr_set | input | NUM_PINS | Set remote IRR per pin |
| hw_irr_clr | input | NUM_PINS | Clear remote IRR per pin |
| hw_dstat_set | input | NUM_PINS | Set delivery status per pin |
| hw_dstat_clr | input | NUM_PINS | Clear delivery status per pin |
| ent_vector | output | NUM_PINS*8 | Vector of each entry |
| ent_dmode | output | NUM_PINS*3 | Delivery mode of each entry |
| ent_dstmode | output | NUM_PINS | Destination mode of each entry |
| ent_polarity | output | NUM_PINS | Polarity of each entry |
| ent_trig | output | NUM_PINS | Trigger mode (1 = level) of each entry |
| ent_mask | output | NUM_PINS | Mask of each entry |
| ent_dstat | output | NUM_PINS | Delivery status of each entry |
| ent_rirr | output | NUM_PINS | Remote IRR of each entry |
| ent_dest | output | NUM_PINS*8 | Destination of each entry |
| lo_wr_pulse | output | 1 | Low-half entry write happened |
| lo_wr_idx | output | IDX_W | Entry index for lo_wr_pulse |

## Verification
Read data and `bus_rvalid` are due one cycle after the read strobe. Register contents, the field exports and `lo_wr_pulse` all change at the edge that samples a write or a status strobe, so each is due in the cycle that follows. The bench drives every input on the falling edge and compares all outputs with its reference model on the next falling edge, which is exactly one sampling edge later. Directed checks read values back through the window in the same way, with expected constants worked out from the requirements.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Internal register selection kinds produced by the decoder
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ID   = 2'd1,
    TGT_VER  = 2'd2,
    TGT_ENT  = 2'd3
  } tgt_e;

  // Select values
  localparam logic [7:0] SELV_ID       = 8'h00;
  localparam logic [7:0] SELV_VER      = 8'h01;
  localparam logic [7:0] SELV_ENT_BASE = 8'h10;

  // Entry bit positions (decoded by the delivery logic)
  localparam int VEC_LSB   = 0;
  localparam int DMODE_LSB = 8;
  localparam int DSTM_BIT  = 11;
  localparam int DSTAT_BIT = 12;
  localparam int POL_BIT   = 13;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;

  localparam int ID_LSB = 24;

  localparam logic [63:0] ENT_RST = 64'(1) << MASK_BIT;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic [7:0]       sel,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);

  localparam logic [7:0] NUM8 = 8'(NUM_PINS);

  logic [7:0] off;
  logic [6:0] raw_idx;

  assign off     = sel - SELV_ENT_BASE;
  assign raw_idx = off[7:1];
  assign hi      = off[0];
  assign idx     = raw_idx[IDX_W-1:0];

  always_comb begin
    if (sel == SELV_ID)                                   tgt = TGT_ID;
    else if (sel == SELV_VER)                             tgt = TGT_VER;
    else if (sel >= SELV_ENT_BASE && {1'b0, raw_idx} < NUM8) tgt = TGT_ENT;
    else                                                  tgt = TGT_NONE;
  end

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_lo_we,
  input  logic        sw_hi_we,
  input  logic [31:0] wdata,
  input  logic        irr_set,
  input  logic        irr_clr,
  input  logic        dstat_set,
  input  logic        dstat_clr,
  output logic [63:0] ent
);

  logic [63:0] ent_q;
  logic [63:0] ent_d;

  always_comb begin
    ent_d = ent_q;
    if (sw_hi_we) ent_d[63:32] = wdata;
    if (sw_lo_we) begin
      ent_d[31:0]      = wdata;
      ent_d[DSTAT_BIT] = 1'b0;
      ent_d[RIRR_BIT]  = ent_q[RIRR_BIT];
    end
    // hardware-owned status
    if (irr_clr)      ent_d[RIRR_BIT] = 1'b0;
    else if (irr_set) ent_d[RIRR_BIT] = 1'b1;
    if (!sw_lo_we) begin
      if (dstat_set)      ent_d[DSTAT_BIT] = 1'b1;
      else if (dstat_clr) ent_d[DSTAT_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_q <= ENT_RST;
    else        ent_q <= ent_d;
  end

  assign ent = ent_q;

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int          NUM_PINS   = 24,
  parameter int          IDX_W      = 5,
  parameter logic [7:0]  VERSION_ID = 8'h11
) (
  input  logic                  hit_sel,
  input  logic                  hit_win,
  input  logic [7:0]            sel,
  input  logic [3:0]            id,
  input  tgt_e                  tgt,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  hi,
  input  logic [NUM_PINS*64-1:0] ent_flat,
  output logic [31:0]           rdata
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_ID};

  logic [63:0] ent_sel;

  always_comb begin
    ent_sel = 64'h0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (idx == IDX_W'(i)) ent_sel = ent_flat[i*64 +: 64];
    end
  end

  always_comb begin
    rdata = 32'h0;
    if (hit_sel) begin
      rdata = {24'h0, sel};
    end else if (hit_win) begin
      unique case (tgt)
        TGT_ID:  rdata = {4'h0, id, 24'h0};
        TGT_VER: rdata = VER_WORD;
        TGT_ENT: rdata = hi ? ent_sel[63:32] : ent_sel[31:0];
        default: rdata = 32'h0;
      endcase
    end
  end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NUM_PINS   = 24,
  parameter logic [7:0] VERSION_ID = 8'h11,
  parameter logic [7:0] SEL_OFS    = 8'h00,
  parameter logic [7:0] WIN_OFS    = 8'h10,
  localparam int        IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  input  logic [NUM_PINS-1:0]    hw_irr_set,
  input  logic [NUM_PINS-1:0]    hw_irr_clr,
  input  logic [NUM_PINS-1:0]    hw_dstat_set,
  input  logic [NUM_PINS-1:0]    hw_dstat_clr,
  output logic [NUM_PINS*8-1:0]  ent_vector,
  output logic [NUM_PINS*3-1:0]  ent_dmode,
  output logic [NUM_PINS-1:0]    ent_dstmode,
  output logic [NUM_PINS-1:0]    ent_polarity,
  output logic [NUM_PINS-1:0]    ent_trig,
  output logic [NUM_PINS-1:0]    ent_mask,
  output logic [NUM_PINS-1:0]    ent_dstat,
  output logic [NUM_PINS-1:0]    ent_rirr,
  output logic [NUM_PINS*8-1:0]  ent_dest,
  output logic                   lo_wr_pulse,
  output logic [IDX_W-1:0]       lo_wr_idx
);

  logic                    hit_sel, hit_win;
  logic [7:0]              sel_q;
  logic [3:0]              id_q;
  tgt_e                    tgt;
  logic [IDX_W-1:0]        idx;
  logic                    hi;
  logic                    win_wr;
  logic                    ent_wr;
  logic [NUM_PINS*64-1:0]  ent_flat;
  logic [31:0]             rd_word;
  logic [31:0]             rdata_q;
  logic                    rvalid_q;
  logic                    pulse_q;
  logic [IDX_W-1:0]        pidx_q;

  assign hit_sel = (bus_addr == SEL_OFS);
  assign hit_win = (bus_addr == WIN_OFS);
  assign win_wr  = bus_wr && hit_win;
  assign ent_wr  = win_wr && (tgt == TGT_ENT);

  irq_route_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .sel (sel_q),
    .tgt (tgt),
    .idx (idx),
    .hi  (hi)
  );

  // select and identification registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 8'h0;
      id_q  <= 4'h0;
    end else begin
      if (bus_wr && hit_sel)            sel_q <= bus_wdata[7:0];
      if (win_wr && (tgt == TGT_ID))    id_q  <= bus_wdata[ID_LSB +: 4];
    end
  end

  // routing entries
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    logic        hit_me;
    logic [63:0] ent;
    assign hit_me = ent_wr && (idx == IDX_W'(g));

    irq_route_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_lo_we  (hit_me && !hi),
      .sw_hi_we  (hit_me && hi),
      .wdata     (bus_wdata),
      .irr_set   (hw_irr_set[g]),
      .irr_clr   (hw_irr_clr[g]),
      .dstat_set (hw_dstat_set[g]),
      .dstat_clr (hw_dstat_clr[g]),
      .ent       (ent)
    );

    assign ent_flat[g*64 +: 64]  = ent;
    assign ent_vector[g*8 +: 8]  = ent[VEC_LSB +: 8];
    assign ent_dmode[g*3 +: 3]   = ent[DMODE_LSB +: 3];
    assign ent_dstmode[g]        = ent[DSTM_BIT];
    assign ent_polarity[g]       = ent[POL_BIT];
    assign ent_trig[g]           = ent[TRIG_BIT];
    assign ent_mask[g]           = ent[MASK_BIT];
    assign ent_dstat[g]          = ent[DSTAT_BIT];
    assign ent_rirr[g]           = ent[RIRR_BIT];
    assign ent_dest[g*8 +: 8]    = ent[DEST_LSB +: 8];
  end

  irq_route_rdmux #(
    .NUM_PINS   (NUM_PINS),
    .IDX_W      (IDX_W),
    .VERSION_ID (VERSION_ID)
  ) u_rd (
    .hit_sel  (hit_sel),
    .hit_win  (hit_win),
    .sel      (sel_q),
    .id       (id_q),
    .tgt      (tgt),
    .idx      (idx),
    .hi       (hi),
    .ent_flat (ent_flat),
    .rdata    (rd_word)
  );

  // registered read return and low-write notification
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= 32'h0;
      rvalid_q <= 1'b0;
      pulse_q  <= 1'b0;
      pidx_q   <= '0;
    end else begin
      rvalid_q <= bus_rd;
      rdata_q  <= bus_rd ? rd_word : 32'h0;
      pulse_q  <= ent_wr && !hi;
      if (ent_wr && !hi) pidx_q <= idx;
    end
  end

  assign bus_rdata   = rdata_q;
  assign bus_rvalid  = rvalid_q;
  assign lo_wr_pulse = pulse_q;
  assign lo_wr_idx   = pidx_q;

endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [31:0]         bus_rdata,
  input logic                bus_rvalid,
  input logic                lo_wr_pulse,
  input logic [IDX_W-1:0]    lo_wr_idx,
  input logic [NUM_PINS-1:0] ent_mask,
  input logic [NUM_PINS-1:0] ent_rirr,
  input logic [NUM_PINS-1:0] hw_irr_set,
  input logic [NUM_PINS-1:0] hw_irr_clr
);

  // R12
  rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));

  // R12
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> (bus_rdata == 32'h0));

  // R10
  pulse_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_pulse |-> $past(bus_wr));

  // R7
  pulse_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_pulse |-> (int'(lo_wr_idx) < NUM_PINS));

  // R9
  mask_moves_on_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ent_mask) |-> lo_wr_pulse);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    // R11
    irr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ent_rirr[g]) |-> $past(hw_irr_set[g]) && !$past(hw_irr_clr[g]));

    // R11
    irr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ent_rirr[g]) |-> $past(hw_irr_clr[g]));
  end

endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_rdata   (bus_rdata),
  .bus_rvalid  (bus_rvalid),
  .lo_wr_pulse (lo_wr_pulse),
  .lo_wr_idx   (lo_wr_idx),
  .ent_mask    (ent_mask),
  .ent_rirr    (ent_rirr),
  .hw_irr_set  (hw_irr_set),
  .hw_irr_clr  (hw_irr_clr)
);

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb;

  localparam int         N     = 24;
  localparam int         IW    = 5;
  localparam logic [7:0] VER   = 8'h11;
  localparam logic [7:0] A_SEL = 8'h00;
  localparam logic [7:0] A_WIN = 8'h10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = 8'h0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = 32'h0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [N-1:0]  hw_irr_set = '0, hw_irr_clr = '0, hw_dstat_set = '0, hw_dstat_clr = '0;
  logic [N*8-1:0] ent_vector, ent_dest;
  logic [N*3-1:0] ent_dmode;
  logic [N-1:0]  ent_dstmode, ent_polarity, ent_trig, ent_mask, ent_dstat, ent_rirr;
  logic          lo_wr_pulse;
  logic [IW-1:0] lo_wr_idx;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  irq_route_regs #(.NUM_PINS(N), .VERSION_ID(VER), .SEL_OFS(A_SEL), .WIN_OFS(A_WIN)) u_dut (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata, .bus_rvalid,
    .hw_irr_set, .hw_irr_clr, .hw_dstat_set, .hw_dstat_clr,
    .ent_vector, .ent_dmode, .ent_dstmode, .ent_polarity, .ent_trig, .ent_mask,
    .ent_dstat, .ent_rirr, .ent_dest, .lo_wr_pulse, .lo_wr_idx
  );

  // ---------------- reference model ----------------
  logic [63:0] m_ent [N];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic [31:0] m_rdata;
  logic        m_rvalid, m_pulse;
  int          m_idx;
  int          m_lo_hit;

  function automatic logic [31:0] mread(input logic [7:0] a);
    int k;
    if (a == A_SEL) return {24'h0, m_sel};
    if (a != A_WIN) return 32'h0;
    if (m_sel == 8'h00) return {4'h0, m_id, 24'h0};
    if (m_sel == 8'h01) return {8'h00, 8'(N - 1), 8'h00, VER};
    if (m_sel < 8'h10) return 32'h0;
    k = (int'(m_sel) - 16) / 2;
    if (k >= N) return 32'h0;
    return m_sel[0] ? m_ent[k][63:32] : m_ent[k][31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_ent[i] = 64'h0000_0000_0001_0000;
      m_sel = 8'h0; m_id = 4'h0; m_rdata = 32'h0; m_rvalid = 1'b0;
      m_pulse = 1'b0; m_idx = 0;
    end else begin
      m_rvalid = bus_rd;
      m_rdata  = bus_rd ? mread(bus_addr) : 32'h0;
      m_pulse  = 1'b0;
      m_lo_hit = -1;
      if (bus_wr && bus_addr == A_SEL) m_sel = bus_wdata[7:0];
      else if (bus_wr && bus_addr == A_WIN) begin
        if (m_sel == 8'h00) m_id = bus_wdata[27:24];
        else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < N) begin
          int k;
          k = (int'(m_sel) - 16) / 2;
          if (m_sel[0]) m_ent[k][63:32] = bus_wdata;
          else begin
            m_ent[k] = {m_ent[k][63:32], bus_wdata[31:15], m_ent[k][14], bus_wdata[13], 1'b0, bus_wdata[11:0]};
            m_pulse = 1'b1; m_idx = k; m_lo_hit = k;
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        if (hw_irr_clr[i]) m_ent[i][14] = 1'b0;
        else if (hw_irr_set[i]) m_ent[i][14] = 1'b1;
        if (m_lo_hit != i) begin
          if (hw_dstat_set[i]) m_ent[i][12] = 1'b1;
          else if (hw_dstat_clr[i]) m_ent[i][12] = 1'b0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      logic [N*8-1:0] ev, ed;
      logic [N*3-1:0] em;
      logic [N-1:0]   edm, ep, et, emk, eds, eri;
      for (int i = 0; i < N; i++) begin
        ev[i*8 +: 8] = m_ent[i][7:0];
        em[i*3 +: 3] = m_ent[i][10:8];
        edm[i] = m_ent[i][11]; eds[i] = m_ent[i][12]; ep[i] = m_ent[i][13];
        eri[i] = m_ent[i][14]; et[i] = m_ent[i][15]; emk[i] = m_ent[i][16];
        ed[i*8 +: 8] = m_ent[i][63:56];
      end
      chk(bus_rvalid == m_rvalid && bus_rdata == m_rdata, "R12 model read",
          {31'h0, bus_rvalid, bus_rdata}, {31'h0, m_rvalid, m_rdata});
      chk(lo_wr_pulse == m_pulse && (!m_pulse || int'(lo_wr_idx) == m_idx), "R10 model pulse",
          {lo_wr_pulse, 63'(lo_wr_idx)}, {m_pulse, 63'(m_idx)});
      chk(ent_vector == ev && ent_dmode == em && ent_dstmode == edm && ent_polarity == ep &&
          ent_trig == et && ent_mask == emk && ent_dstat == eds && ent_rirr == eri && ent_dest == ed,
          "R13 model exports", 64'(ent_vector), 64'(ev));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_win(input logic [7:0] s, output logic [31:0] d);
    wr(A_SEL, {24'h0, s});
    rd(A_WIN, d);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ent_mask == {N{1'b1}}, "R1 masks after reset", 64'(ent_mask), 64'({N{1'b1}}));
    rd(A_SEL, d);        chk(d == 32'h0, "R1 select reset", d, 0);
    rd_win(8'h10, d);    chk(d == 32'h0001_0000, "R1 entry0 low", d, 32'h0001_0000);
    rd_win(8'h3F, d);    chk(d == 32'h0, "R1 entry23 high", d, 0);
    rd_win(8'h00, d);    chk(d == 32'h0, "R1 id reset", d, 0);

    // R3 select width
    wr(A_SEL, 32'h1234_56AB);
    rd(A_SEL, d);        chk(d == 32'h0000_00AB, "R3 select readback", d, 32'hAB);

    // R2 other offsets
    rd(8'h04, d);        chk(d == 32'h0, "R2 unmapped read", d, 0);
    wr(8'h20, 32'h0000_0055);
    rd(A_SEL, d);        chk(d == 32'h0000_00AB, "R2 unmapped write ignored", d, 32'hAB);

    // R4 version
    rd_win(8'h01, d);    chk(d == 32'h0017_0011, "R4 version", d, 32'h0017_0011);
    wr(A_WIN, 32'hFFFF_FFFF);
    rd(A_WIN, d);        chk(d == 32'h0017_0011, "R4 version write ignored", d, 32'h0017_0011);

    // R5 id
    wr(A_SEL, 32'h0); wr(A_WIN, 32'hFFFF_FFFF);
    rd(A_WIN, d);        chk(d == 32'h0F00_0000, "R5 id field", d, 32'h0F00_0000);

    // R6/R9/R13 entry 3 low half
    wr(A_SEL, 32'h16); wr(A_WIN, 32'hFFFF_FFFF);
    chk(lo_wr_pulse && lo_wr_idx == 5'd3, "R10 pulse after low write", {lo_wr_pulse, 63'(lo_wr_idx)}, {1'b1, 63'd3});
    rd(A_WIN, d);        chk(d == 32'hFFFF_AFFF, "R9 status bits protected", d, 32'hFFFF_AFFF);
    chk(ent_vector[3*8 +: 8] == 8'hFF && ent_dmode[3*3 +: 3] == 3'd7 && ent_dstmode[3] && ent_polarity[3]
        && ent_trig[3] && ent_mask[3], "R13 field exports entry3", 64'(ent_vector[3*8 +: 8]), 64'hFF);
    rd_win(8'h14, d);    chk(d == 32'h0001_0000, "R6 neighbour entry2 untouched", d, 32'h0001_0000);

    // R8 high half
    wr(A_SEL, 32'h17); wr(A_WIN, 32'hA500_0000);
    chk(!lo_wr_pulse, "R10 no pulse on high write", 64'(lo_wr_pulse), 0);
    rd(A_WIN, d);        chk(d == 32'hA500_0000, "R8 high readback", d, 32'hA500_0000);
    chk(ent_dest[3*8 +: 8] == 8'hA5, "R8 dest export", 64'(ent_dest[3*8 +: 8]), 64'hA5);
    rd_win(8'h16, d);    chk(d == 32'hFFFF_AFFF, "R8 low kept", d, 32'hFFFF_AFFF);

    // R11 hardware status
    hw_irr_set[3] = 1'b1; @(negedge clk); hw_irr_set[3] = 1'b0;
    rd(A_WIN, d);        chk(d == 32'hFFFF_EFFF, "R11 irr set", d, 32'hFFFF_EFFF);
    hw_dstat_set[3] = 1'b1; @(negedge clk); hw_dstat_set[3] = 1'b0;
    rd(A_WIN, d);        chk(d == 32'hFFFF_FFFF, "R11 dstat set", d, 32'hFFFF_FFFF);
    wr(A_WIN, 32'h0000_0020);
    rd(A_WIN, d);        chk(d == 32'h0000_4020, "R9 irr kept dstat cleared", d, 32'h0000_4020);
    chk(ent_vector[3*8 +: 8] == 8'h20 && !ent_mask[3] && !ent_trig[3], "R13 exports after rewrite",
        64'(ent_vector[3*8 +: 8]), 64'h20);
    hw_dstat_set[3] = 1'b1; wr(A_WIN, 32'h0000_1020); hw_dstat_set[3] = 1'b0;
    rd(A_WIN, d);        chk(d == 32'h0000_4020, "R9 low write beats dstat set", d, 32'h0000_4020);
    hw_irr_set[3] = 1'b1; hw_irr_clr[3] = 1'b1; @(negedge clk);
    hw_irr_set[3] = 1'b0; hw_irr_clr[3] = 1'b0;
    rd(A_WIN, d);        chk(d == 32'h0000_0020, "R11 clear beats set", d, 32'h0000_0020);

    // R7 out of range / reserved selects
    wr(A_SEL, 32'h40); wr(A_WIN, 32'h1234_5678);
    chk(!lo_wr_pulse, "R7 no pulse out of range", 64'(lo_wr_pulse), 0);
    rd(A_WIN, d);        chk(d == 32'h0, "R7 out of range read", d, 0);
    rd_win(8'h05, d);    chk(d == 32'h0, "R7 reserved select read", d, 0);
    rd_win(8'h3E, d);    chk(d == 32'h0001_0000, "R7 last entry in range", d, 32'h0001_0000);
    wr(A_SEL, 32'h3E); wr(A_WIN, 32'h0000_0042);
    chk(lo_wr_pulse && lo_wr_idx == 5'd23, "R10 pulse last entry", {lo_wr_pulse, 63'(lo_wr_idx)}, {1'b1, 63'd23});
    @(negedge clk);
    chk(!lo_wr_pulse, "R10 pulse lasts one cycle", 64'(lo_wr_pulse), 0);

    // R12 idle and latency
    chk(!bus_rvalid && bus_rdata == 32'h0, "R12 idle read port", {31'h0, bus_rvalid, bus_rdata}, 0);

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      int op;
      op = $urandom_range(0, 5);
      bus_rd = 1'b0; bus_wr = 1'b0;
      hw_irr_set   = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
      hw_irr_clr   = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
      hw_dstat_set = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
      hw_dstat_clr = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
      bus_wdata = $urandom;
      case (op)
        0: begin bus_addr = A_SEL; bus_wr = 1'b1; bus_wdata = {$urandom, 8'($urandom_range(0, 8'h44))}; end
        1: begin bus_addr = A_WIN; bus_wr = 1'b1; end
        2: begin bus_addr = A_WIN; bus_rd = 1'b1; end
        3: begin bus_addr = A_SEL; bus_rd = 1'b1; end
        4: begin bus_addr = 8'($urandom); bus_rd = 1'b1; bus_wr = $urandom_range(0, 1) == 1; end
        default: ;
      endcase
      @(negedge clk);
    end
    bus_rd = 1'b0; bus_wr = 1'b0;
    hw_irr_set = '0; hw_irr_clr = '0; hw_dstat_set = '0; hw_dstat_clr = '0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule